// File: doc/BRIEF.md
# Oversampled Serial Receive Front-End

This block turns an asynchronous serial line into received bytes. It runs from the system clock, with an enable tick that pulses at sixteen times the bit rate. The line rests high. A frame opens with a low start bit, carries seven or eight data bits least significant first, and closes with one high stop bit. There is no parity.

The incoming line passes through a flop synchronizer. The block then watches for a high-to-low change between two successive ticks, and that change restarts its tick counter. Three samples are taken in the middle of every bit period, at counts 7, 8 and 9 of 16, and a two-of-three vote decides the bit value. A start bit whose vote is high is taken as a spike, and the receiver goes back to waiting. At the stop-bit vote the block emits a one-cycle strobe. The assembled byte and a framing-error flag arrive with that strobe and stay unchanged until the next one.

Top module: `uart_rx_frontend`

## Requirements
- R1: While rst_n is low and in the cycle after it, byte_valid and frame_err are 0 and byte_data is all zeros.
- R2: A frame starts only on a high-to-low change of the synchronized line seen between two ticks. A line that is already low when reset is released and stays low yields no byte.
- R3: A low pulse that ends before count 8 of the start bit (count 0 being the first tick that sees it low) yields no byte. A frame that follows it is received normally.
- R4: A start bit that is low at two of the counts 7, 8 and 9, including a single high tick at count 8, is accepted.
- R5: In 8-bit mode (short_len=0) the first data bit on the line ends up in byte_data[0] and the eighth in byte_data[7].
- R6: In 7-bit mode (short_len=1) seven data bits are taken, the stop bit follows the seventh, and byte_data[7] is 0. short_len is captured at the start edge.
- R7: Each data bit is the majority of its samples at counts 7, 8 and 9. A single inverted tick at count 8 does not change the bit.
- R8: byte_valid is a one-cycle pulse in the clock cycle after the tick at count 9 of the stop bit. byte_data and frame_err change only together with that pulse.
- R9: frame_err is 1 when the stop-bit vote is low and 0 when it is high. The byte is delivered in both cases.
- R10: After a framing error no new frame starts until the line has been seen high at a tick. A line held low after the bad stop bit yields no further byte.
- R11: The falling edge of the next start bit may arrive at the tick right after the stop-bit vote (count 10 of the stop bit). Both bytes are then received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| short_len | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | DATA_W | Received byte, LSB received first |
| frame_err | output | 1 | Stop bit was voted low for this byte |

## Verification
The stop-bit vote of one frame and the start-edge detection of the next can fall on neighbouring ticks. The bench provokes this by cutting the stop bit to ten ticks, so the next start's falling edge reaches the synchronized line at count 10, one tick after the vote. It passes only if the strobe and data of the first frame are correct and the second frame is also received intact. That shows the edge detector holds a valid "previous high" sample at the very tick the controller goes back to idle.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the oversampled serial receiver.
// Assumes nothing beyond standard SystemVerilog packages.
package uart_rx_pkg;

    // Receiver controller states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_STOP  = 3'd3,
        ST_HOLD  = 3'd4
    } rx_state_e;

    // Two-of-three majority of single-bit samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Multi-stage flop synchronizer for the asynchronous serial line.
// Assumes STAGES >= 2. Resets to low, so a line that is low when
// reset is released never looks like a falling edge.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Pass the value one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rx_vote.sv
// Three-point mid-bit sampler with a two-of-three vote.
// Stores the samples at the two points before centre+1 and combines them
// with the live sample at centre+1. Assumes cnt is the sub-bit count
// kept by the controller and that OVERSAMPLE >= 4.
module rx_vote
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int CNT_W      = $clog2(OVERSAMPLE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             din,
    output logic             decide,
    output logic             vote_high
);

    localparam int PT_B = OVERSAMPLE / 2;
    localparam int PT_A = PT_B - 1;
    localparam int PT_C = PT_B + 1;

    logic samp_a;
    logic samp_b;

    // Capture the first two sample points of the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a <= 1'b1;
            samp_b <= 1'b1;
        end else if (tick) begin
            if (cnt == CNT_W'(PT_A)) samp_a <= din;
            if (cnt == CNT_W'(PT_B)) samp_b <= din;
        end
    end

    // The vote resolves on the tick at the third sample point.
    always_comb begin
        decide    = tick && (cnt == CNT_W'(PT_C));
        vote_high = maj3(samp_a, samp_b, din);
    end

endmodule

// File: rtl/rx_ctrl.sv
// Frame controller: start-edge detection, sub-bit counting, bit indexing,
// LSB-first assembly, stop-bit check and output registers.
// Assumes decide/vote_high come from rx_vote driven by this module's cnt.
module rx_ctrl
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = $clog2(OVERSAMPLE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              short_len,
    input  logic              decide,
    input  logic              vote_high,
    output logic [CNT_W-1:0]  cnt,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              frame_err,
    output logic              len_short_q
);

    localparam int IDX_W    = $clog2(DATA_W + 1);
    localparam int CNT_LAST = OVERSAMPLE - 1;

    rx_state_e         state;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    logic              line_prev;
    logic [IDX_W-1:0]  nbits;
    logic              wrap;
    logic              fall;

    // Bits expected in this frame, end of a bit period, start edge.
    always_comb begin
        nbits = len_short_q ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W);
        wrap  = tick && (cnt == CNT_W'(CNT_LAST));
        fall  = tick && line_prev && !rx_s;
    end

    // Line history sampled once per tick for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)    line_prev <= 1'b0;
        else if (tick) line_prev <= rx_s;
    end

    // Frame sequencing, counting, assembly and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            idx         <= '0;
            shreg       <= '0;
            len_short_q <= 1'b0;
            byte_valid  <= 1'b0;
            byte_data   <= '0;
            frame_err   <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (tick && state != ST_IDLE && state != ST_HOLD)
                cnt <= wrap ? '0 : cnt + 1'b1;
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        state       <= ST_START;
                        cnt         <= CNT_W'(1);
                        idx         <= '0;
                        shreg       <= '0;
                        len_short_q <= short_len;
                    end
                end
                ST_START: begin
                    if (decide && vote_high) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else if (wrap) begin
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (decide) begin
                        shreg <= {vote_high, shreg[DATA_W-1:1]};
                        idx   <= idx + 1'b1;
                    end
                    if (wrap && idx == nbits) state <= ST_STOP;
                end
                ST_STOP: begin
                    if (decide) begin
                        byte_valid <= 1'b1;
                        frame_err  <= !vote_high;
                        byte_data  <= len_short_q ? {1'b0, shreg[DATA_W-1:1]} : shreg;
                        state      <= vote_high ? ST_IDLE : ST_HOLD;
                        cnt        <= '0;
                    end
                end
                ST_HOLD: begin
                    if (tick && rx_s) state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_frontend.sv
// Top level of the oversampled serial receive front-end.
// Chains synchronizer, frame controller and mid-bit voter. Assumes tick
// is a single-cycle enable at OVERSAMPLE times the bit rate.
module uart_rx_frontend #(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    input  logic              short_len,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              frame_err
);

    localparam int CNT_W = $clog2(OVERSAMPLE);

    logic             rx_s;
    logic [CNT_W-1:0] cnt;
    logic             decide;
    logic             vote_high;
    logic             len_short_q;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .dout  (rx_s)
    );

    rx_vote #(.OVERSAMPLE(OVERSAMPLE), .CNT_W(CNT_W)) u_vote (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt       (cnt),
        .din       (rx_s),
        .decide    (decide),
        .vote_high (vote_high)
    );

    rx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rx_s        (rx_s),
        .short_len   (short_len),
        .decide      (decide),
        .vote_high   (vote_high),
        .cnt         (cnt),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .frame_err   (frame_err),
        .len_short_q (len_short_q)
    );

endmodule

// File: rtl/uart_rx_frontend_chk.sv
// Property checker for uart_rx_frontend, attached by bind below.
// Assumes the top exposes len_short_q, the length captured at the start edge.
module uart_rx_frontend_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              byte_valid,
    input logic [DATA_W-1:0] byte_data,
    input logic              frame_err,
    input logic              len_short_q
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!byte_valid && !frame_err && byte_data == '0));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    assert_strobe_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(tick));

    assert_outputs_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |-> ($stable(byte_data) && $stable(frame_err)));

    assert_short_msb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && len_short_q) |-> !byte_data[DATA_W-1]);

endmodule

bind uart_rx_frontend uart_rx_frontend_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .frame_err   (frame_err),
    .len_short_q (len_short_q)
);

// File: tb/tb_uart_rx_frontend.sv
// Self-checking bench: table-driven frames, then directed corner cases.
module tb_uart_rx_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int NVEC       = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx_in = 1'b0;
    logic       short_len = 1'b0;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       frame_err;

    int nchk = 0;
    int nfail = 0;
    int npulse = 0;
    int nwide = 0;
    logic [7:0] cap_data [0:63];
    logic       cap_err  [0:63];
    logic       prev_valid = 1'b0;
    int         divc = 0;

    // Vector: {data[22:15], short[14], stop[13], glitch[12:9], exp_data[8:1], exp_err[0]}
    // glitch: 0 = start bit, k = data bit k-1, 15 = none
    localparam logic [22:0] VEC [NVEC] = '{
        {8'hA5, 1'b0, 1'b1, 4'd15, 8'hA5, 1'b0},
        {8'h3C, 1'b0, 1'b1, 4'd15, 8'h3C, 1'b0},
        {8'h01, 1'b0, 1'b1, 4'd15, 8'h01, 1'b0},
        {8'h80, 1'b0, 1'b1, 4'd15, 8'h80, 1'b0},
        {8'h55, 1'b1, 1'b1, 4'd15, 8'h55, 1'b0},
        {8'hFF, 1'b1, 1'b1, 4'd15, 8'h7F, 1'b0},
        {8'hC3, 1'b0, 1'b1, 4'd0,  8'hC3, 1'b0},
        {8'h00, 1'b0, 1'b1, 4'd4,  8'h00, 1'b0},
        {8'hFF, 1'b0, 1'b1, 4'd8,  8'hFF, 1'b0},
        {8'h96, 1'b0, 1'b0, 4'd15, 8'h96, 1'b1},
        {8'h2A, 1'b1, 1'b0, 4'd15, 8'h2A, 1'b1},
        {8'h7E, 1'b0, 1'b1, 4'd15, 8'h7E, 1'b0}
    };

    uart_rx_frontend dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rx_in      (rx_in),
        .short_len  (short_len),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_err  (frame_err)
    );

    // Free-running clock.
    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick every TICK_DIV clocks, changed on the falling edge.
    always @(negedge clk) begin
        divc = (divc == TICK_DIV - 1) ? 0 : divc + 1;
        tick = (divc == TICK_DIV - 1);
    end

    // Output monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (byte_valid) begin
            if (npulse < 64) begin
                cap_data[npulse] = byte_data;
                cap_err[npulse]  = frame_err;
            end
            npulse = npulse + 1;
            if (prev_valid) nwide = nwide + 1;
        end
        prev_valid = byte_valid;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!tick);
    endtask

    // Drive a level for n ticks; called and returning at a falling edge.
    task automatic set_line(input logic v, input int n);
        rx_in = v;
        for (int k = 0; k < n; k++) wait_tick();
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic sl, input logic stopv,
                              input int glitch, input int stoplen, input int idlelen);
        int nb;
        nb = sl ? 7 : 8;
        short_len = sl;
        if (glitch == 0) begin
            set_line(1'b0, 8); set_line(1'b1, 1); set_line(1'b0, 7);
        end else begin
            set_line(1'b0, 16);
        end
        for (int i = 0; i < nb; i++) begin
            if (glitch == i + 1) begin
                set_line(d[i], 8); set_line(~d[i], 1); set_line(d[i], 7);
            end else begin
                set_line(d[i], 16);
            end
        end
        set_line(stopv, stoplen);
        if (idlelen > 0) set_line(1'b1, idlelen);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        nfail = nfail + 1;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        int base;
        string tag;
        logic [22:0] v;
        // R1: reset state, line low throughout reset.
        rx_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R1", {31'd0, byte_valid}, 32'd0);
        check("R1", {24'd0, byte_data}, 32'd0);
        check("R1", {31'd0, frame_err}, 32'd0);
        rst_n = 1'b1;
        // R2: line stays low after reset; no frame may start.
        set_line(1'b0, 60);
        check("R2", npulse, 0);
        set_line(1'b1, 20);
        // R3: short low pulses rejected at the start vote.
        base = npulse;
        set_line(1'b0, 6);  set_line(1'b1, 30);
        set_line(1'b0, 8);  set_line(1'b1, 30);
        check("R3", npulse, base);
        // Table walk.
        for (int r = 0; r < NVEC; r++) begin
            v = VEC[r];
            if (v[14])           tag = "R6";
            else if (!v[13])     tag = "R9";
            else if (v[12:9] == 4'd0)  tag = "R4";
            else if (v[12:9] != 4'd15) tag = "R7";
            else                 tag = "R5";
            base = npulse;
            send_frame(v[22:15], v[14], v[13], int'(v[12:9]), 16, 20);
            check(tag, npulse, base + 1);
            check(tag, {24'd0, cap_data[base]}, {24'd0, v[8:1]});
            check(tag, {31'd0, cap_err[base]}, {31'd0, v[0]});
        end
        // R3: frame after rejected pulses is received (table row 0 covered); one more.
        base = npulse;
        set_line(1'b0, 5); set_line(1'b1, 25);
        send_frame(8'h69, 1'b0, 1'b1, 15, 16, 20);
        check("R3", npulse, base + 1);
        check("R3", {24'd0, cap_data[base]}, 32'h69);
        // R10: bad stop, line held low afterwards.
        base = npulse;
        send_frame(8'h00, 1'b0, 1'b0, 15, 16, 0);
        set_line(1'b0, 60);
        check("R10", npulse, base + 1);
        check("R10", {31'd0, cap_err[base]}, 32'd1);
        set_line(1'b1, 20);
        send_frame(8'h5A, 1'b0, 1'b1, 15, 16, 20);
        check("R10", npulse, base + 2);
        check("R10", {24'd0, cap_data[base+1]}, 32'h5A);
        // R11: next start edge one tick after the stop vote.
        base = npulse;
        send_frame(8'h11, 1'b0, 1'b1, 15, 10, 0);
        send_frame(8'hE7, 1'b0, 1'b1, 15, 16, 20);
        check("R11", npulse, base + 2);
        check("R11", {24'd0, cap_data[base]}, 32'h11);
        check("R11", {24'd0, cap_data[base+1]}, 32'hE7);
        check("R11", {30'd0, cap_err[base], cap_err[base+1]}, 32'd0);
        // R8: held outputs and single-cycle strobe.
        check("R8", {24'd0, byte_data}, 32'hE7);
        check("R8", nwide, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule